// File: doc/BRIEF.md
# Set-on-Compare Unit

This block is an integer compare stage that produces a boolean result, 0 or 1, zero-extended to a full 64-bit register value. A 3-bit extended-opcode field picks the operation. Code 0 is the base set-less-than. The other defined codes turn the same datapath into greater-or-equal, equal, not-equal, an AND-based "any bit common" test, and its negation. Every operation can take its second operand either from a register or from a 12-bit immediate, which is sign-extended to 64 bits.

A signedness select applies to the two ordered compares and has no effect on the others. The result is registered. A valid strobe travels with the operation, so a new operation can be issued on every cycle. A synchronous reset clears the output stage.

Top module: `setcmp_unit`

## Requirements
- R1: With `ext_op` = 0 (set-less-than), `out_result` is 1 when `src_a` is less than the second operand, and 0 otherwise.
- R2: With `ext_op` = 1 (set-greater-or-equal), `out_result` is 1 when `src_a` is greater than or equal to the second operand.
- R3: With `ext_op` = 2, `out_result` is 1 when the operands are equal. With `ext_op` = 3, it is 1 when they differ.
- R4: With `ext_op` = 4, `out_result` is 1 when the bitwise AND of the operands is nonzero. With `ext_op` = 5, it is 1 when that AND is zero.
- R5: With `use_imm` = 1, the second operand is `imm12` sign-extended to 64 bits, and `src_b` is ignored. With `use_imm` = 0, the second operand is `src_b`.
- R6: `is_unsigned` = 1 makes codes 0 and 1 compare as unsigned, and 0 makes them compare as two's-complement signed. Codes 2 to 5 give the same result for either value of `is_unsigned`.
- R7: Bits 63:1 of `out_result` are always 0.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. The result of an operation accepted on a clock edge appears after that edge.
- R9: When `rst` is high on a clock edge, `out_valid` and `out_result` are 0 after that edge, whatever `in_valid` is.
- R10: `ext_op` codes 6 and 7 are undefined. They produce `out_result` = 0, and `out_valid` is still asserted.
- R11: While `in_valid` is low, `out_result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| ext_op | input | 3 | Extended opcode selecting the compare or test |
| is_unsigned | input | 1 | Unsigned ordering for codes 0 and 1 |
| use_imm | input | 1 | Use the immediate as the second operand |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, register form |
| imm12 | input | 12 | Immediate, sign-extended before use |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Zero-extended 0/1 result |

## Verification
Two events can fall on the same edge. A new operation is captured on the edge that presents the previous result, and a reset can arrive in the same cycle as a valid operation. The bench drives its vector table back to back, one operation per cycle, and samples every result on the falling edge that follows its capture edge. It also issues a valid equality whose result would be 1 while reset is high, and requires a zero result with valid low. A further cycle with `in_valid` low and changed operands checks that the last result is held.

// File: rtl/setcmp_pkg.sv
package setcmp_pkg;

  typedef enum logic [2:0] {
    SC_LT   = 3'd0,
    SC_GE   = 3'd1,
    SC_EQ   = 3'd2,
    SC_NE   = 3'd3,
    SC_TST  = 3'd4,
    SC_NTST = 3'd5
  } sc_op_e;

  // True for the extended-opcode codes that name an operation.
  function automatic logic op_known(input logic [2:0] code);
    return (code <= 3'd5);
  endfunction

  // Map the shared comparison flags to the selected boolean.
  function automatic logic pick_result(input logic [2:0] code,
                                       input logic lt,
                                       input logic eq,
                                       input logic any_common);
    logic r;
    case (code)
      SC_LT:   r = lt;
      SC_GE:   r = ~lt;
      SC_EQ:   r = eq;
      SC_NE:   r = ~eq;
      SC_TST:  r = any_common;
      SC_NTST: r = ~any_common;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/setcmp_operand.sv
module setcmp_operand #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 12
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] rhs
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
  assign rhs     = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/setcmp_magcmp.sv
module setcmp_magcmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic              signed_mode,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              lt,
  output logic              eq
);
  localparam int NLANE = DATA_W / LANE_W;

  logic [DATA_W-1:0] lhs_b;
  logic [DATA_W-1:0] rhs_b;
  logic [NLANE-1:0]  lane_lt;
  logic [NLANE-1:0]  lane_eq;

  // Inverting the sign bit turns a signed order into an unsigned one.
  assign lhs_b = {lhs[DATA_W-1] ^ signed_mode, lhs[DATA_W-2:0]};
  assign rhs_b = {rhs[DATA_W-1] ^ signed_mode, rhs[DATA_W-2:0]};

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      logic [LANE_W-1:0] la;
      logic [LANE_W-1:0] lb;
      assign la         = lhs_b[g*LANE_W +: LANE_W];
      assign lb         = rhs_b[g*LANE_W +: LANE_W];
      assign lane_lt[g] = (la < lb);
      assign lane_eq[g] = (la == lb);
    end
  endgenerate

  // Combine the lanes, most significant first.
  always_comb begin
    logic lt_acc;
    logic eq_acc;
    lt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = NLANE - 1; i >= 0; i--) begin
      lt_acc = lt_acc | (eq_acc & lane_lt[i]);
      eq_acc = eq_acc & lane_eq[i];
    end
    lt = lt_acc;
    eq = eq_acc;
  end
endmodule

// File: rtl/setcmp_bittest.sv
module setcmp_bittest #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              any_common
);
  assign any_common = |(lhs & rhs);
endmodule

// File: rtl/setcmp_unit.sv
module setcmp_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 12,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        ext_op,
  input  logic              is_unsigned,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm12,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  import setcmp_pkg::*;

  localparam int PAD_W = DATA_W - 1;

  logic [DATA_W-1:0] rhs_sel;
  logic              cmp_lt;
  logic              cmp_eq;
  logic              cmp_any;
  logic              op_legal;
  logic              bit_next;

  setcmp_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
    .use_imm (use_imm),
    .reg_val (src_b),
    .imm_val (imm12),
    .rhs     (rhs_sel)
  );

  setcmp_magcmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_magcmp (
    .signed_mode (~is_unsigned),
    .lhs         (src_a),
    .rhs         (rhs_sel),
    .lt          (cmp_lt),
    .eq          (cmp_eq)
  );

  setcmp_bittest #(.DATA_W(DATA_W)) u_bittest (
    .lhs        (src_a),
    .rhs        (rhs_sel),
    .any_common (cmp_any)
  );

  assign op_legal = op_known(ext_op);
  assign bit_next = pick_result(ext_op, cmp_lt, cmp_eq, cmp_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= {{PAD_W{1'b0}}, bit_next};
    end
  end
endmodule

// File: rtl/setcmp_unit_chk.sv
module setcmp_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        ext_op,
  input logic              use_imm,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              op_legal,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    // R9
    if (prev_rst) begin
      reset_clear_chk: assert (!out_valid && out_result == '0)
        else $error("output not cleared after reset");
    end
  end

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_result[DATA_W-1:1] == '0);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_legal) |=> (out_valid && out_result == '0));

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  // R3
  eq_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ext_op == 3'd2 && !use_imm && src_a == src_b)
      |=> out_result[0]);

  // R3
  ne_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ext_op == 3'd3 && !use_imm && src_a == src_b)
      |=> out_result == '0);
endmodule

bind setcmp_unit setcmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .ext_op     (ext_op),
  .use_imm    (use_imm),
  .src_a      (src_a),
  .src_b      (src_b),
  .op_legal   (op_legal),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/setcmp_unit_tb.sv
module setcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  ext_op;
  logic        is_unsigned;
  logic        use_imm;
  logic [63:0] src_a;
  logic [63:0] src_b;
  logic [11:0] imm12;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  setcmp_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ext_op(ext_op),
    .is_unsigned(is_unsigned), .use_imm(use_imm), .src_a(src_a),
    .src_b(src_b), .imm12(imm12), .out_valid(out_valid),
    .out_result(out_result)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        uns;
    logic        imm;
    logic [63:0] a;
    logic [63:0] b;
    logic [11:0] i;
    logic        exp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 1'b1},                   // R1 R6 signed -1<1
    '{3'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 12'h0, 1'b0},                   // R1 R6 unsigned
    '{3'd1, 1'b0, 1'b0, 64'h5, 64'h5, 12'h0, 1'b1},                                     // R2 equal
    '{3'd1, 1'b1, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 1'b0},                   // R2 R6
    '{3'd2, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 12'h0, 1'b1}, // R3 R6
    '{3'd2, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 12'h0, 1'b0}, // R3
    '{3'd3, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 12'h0, 1'b1},                   // R3 top bit
    '{3'd3, 1'b1, 1'b0, 64'h5, 64'h5, 12'h0, 1'b0},                                     // R3 R6
    '{3'd4, 1'b0, 1'b0, 64'hF0, 64'h0F, 12'h0, 1'b0},                                   // R4 disjoint
    '{3'd4, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 1'b1}, // R4 R6
    '{3'd5, 1'b0, 1'b0, 64'hF0, 64'h0F, 12'h0, 1'b1},                                   // R4 negated
    '{3'd5, 1'b0, 1'b0, 64'h3, 64'h2, 12'h0, 1'b0},                                     // R4 negated
    '{3'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h8000_0000_0000_0000, 12'hFFC, 1'b1}, // R5 R1 -5<-4
    '{3'd0, 1'b1, 1'b1, 64'h1_0000, 64'h0, 12'hFFF, 1'b1},                             // R5 R6 sign-extend
    '{3'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'hFFF, 1'b1},                 // R5 R3
    '{3'd1, 1'b0, 1'b1, 64'h0, 64'h1, 12'h800, 1'b1},                                   // R5 R2 0>=-2048
    '{3'd6, 1'b0, 1'b0, 64'h1, 64'h2, 12'h0, 1'b0},                                     // R10
    '{3'd7, 1'b1, 1'b0, 64'h9, 64'h9, 12'h0, 1'b0},                                     // R10
    '{3'd0, 1'b0, 1'b0, 64'h0001_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 12'h0, 1'b0}, // R1 lane edge
    '{3'd1, 1'b0, 1'b0, 64'h0001_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 12'h0, 1'b1}, // R2 lane edge
    '{3'd0, 1'b0, 1'b0, 64'h1234_0000_0000_0001, 64'h1234_0000_0000_0002, 12'h0, 1'b1}, // R1 low lane
    '{3'd0, 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 12'h0, 1'b0}, // R1 R6 signed
    '{3'd0, 1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 12'h0, 1'b1}  // R6 unsigned
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; ext_op = 3'd0; is_unsigned = 1'b0;
    use_imm = 1'b0; src_a = '0; src_b = '0; imm12 = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset valid", {63'b0, out_valid}, 64'h0);
    chk("R9 reset result", out_result, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    // R8: idle cycle after reset keeps valid low
    chk("R8 idle valid", {63'b0, out_valid}, 64'h0);

    // Back-to-back table walk: R1..R7, R10
    for (int k = 0; k < NV; k++) begin
      ext_op = VECS[k].op; is_unsigned = VECS[k].uns; use_imm = VECS[k].imm;
      src_a = VECS[k].a; src_b = VECS[k].b; imm12 = VECS[k].i;
      in_valid = 1'b1;
      @(negedge clk);
      chk($sformatf("R8 valid vec%0d", k), {63'b0, out_valid}, 64'h1);
      chk($sformatf("R7 result vec%0d", k), out_result, {63'b0, VECS[k].exp});
    end

    // R11: hold with in_valid low, operands changed (last result was 1)
    in_valid = 1'b0; ext_op = 3'd2; src_a = 64'h1; src_b = 64'h2;
    @(negedge clk);
    chk("R8 valid drop", {63'b0, out_valid}, 64'h0);
    chk("R11 hold", out_result, 64'h1);
    @(negedge clk);
    chk("R11 hold 2", out_result, 64'h1);

    // R10 followed by hold of zero
    in_valid = 1'b1; ext_op = 3'd6; src_a = 64'h3; src_b = 64'h3;
    @(negedge clk);
    chk("R10 valid", {63'b0, out_valid}, 64'h1);
    chk("R10 zero", out_result, 64'h0);

    // R5: src_b ignored in immediate form
    ext_op = 3'd2; use_imm = 1'b1; src_a = 64'h7; src_b = 64'h7; imm12 = 12'h008;
    @(negedge clk);
    chk("R5 ignore src_b", out_result, 64'h0);

    // R9: reset coinciding with a valid operation that would give 1
    rst = 1'b1; ext_op = 3'd2; use_imm = 1'b0; src_a = 64'hA; src_b = 64'hA;
    in_valid = 1'b1;
    @(negedge clk);
    // prime a 1 first is not possible under reset; expect cleared state
    chk("R9 reset with valid", {63'b0, out_valid}, 64'h0);
    chk("R9 reset result", out_result, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 after reset", out_result, 64'h1);
    chk("R8 after reset", {63'b0, out_valid}, 64'h1);
    in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule